// File: doc/BRIEF.md
# DMA Event Capture and Prioritizer

This block watches a set of already-synchronized DMA request lines and records every low-to-high transition as a pending event. The pending bit is set whether or not software has enabled that channel. Among the pending events that are also enabled, a fixed-priority arbiter picks one. It offers that channel to a transfer controller through a valid/ready handshake. The pending bit drops on the cycle the controller accepts the channel.

A request can arrive on an enabled channel while its earlier request is still pending. The new request is not queued. Instead it sets a sticky missed flag for that channel. Software reads the pending, enable and missed words through a simple word-addressed register port. It clears pending bits or missed flags by writing ones to two write-only clear locations. Reads of the register port are combinational.

Top module: `dma_evt_prio`

## Requirements
- R1: There are 20 event channels. Address 0 reads the pending bits, with channel n in bit n and bits 31:20 as zero. Writes to address 0 change nothing.
- R2: A pending bit is set in the clock edge after its input is seen high while it was low one cycle earlier, independent of the enable bit. The stored previous value resets to 0, so an input already high when reset ends is taken as a rising edge.
- R3: Only channels that are both pending and enabled compete. `sub_valid` is low when no such channel exists.
- R4: The lowest-numbered competing channel wins, and its number is given on `sub_chan`.
- R5: The offered channel stays offered while `sub_ready` is low. Its pending bit clears at the edge where `sub_valid` and `sub_ready` are both high.
- R6: Writing to address 2 clears each pending bit whose data bit is 1. Data bits of 0 leave the bit alone, and address 2 reads as zero.
- R7: If a rising edge and a clear (by acceptance or by an address 2 write) reach the same pending bit at the same edge, the bit stays set.
- R8: A missed flag (address 3, bit n for channel n) is set by a rising edge on a channel that is already pending and enabled. It is not set when the channel is disabled, or when the edge coincides with that channel's acceptance.
- R9: Missed flags stay set until software writes 1 to the matching bit at address 4. Data bits of 0 leave them set.
- R10: Address 1 is a read/write enable mask of 20 bits. Bits 31:20 read as zero.
- R11: After reset the pending, enable and missed words read zero and `sub_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 20 | Synchronized event request levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sub_valid | output | 1 | A channel is offered to the transfer controller |
| sub_chan | output | 5 | Number of the offered channel |
| sub_ready | input | 1 | Transfer controller accepts the offered channel |

## Verification
On every cycle, the bound checker confirms the following. The offered channel is pending, enabled and lowest-numbered. An edge always leaves its pending bit set. An accepted channel's bit drops unless a new edge hit it. Missed flags only appear on channels that were pending and enabled, and only fall on a missed-clear write. Some behaviours can only be shown by the bench's directed scenarios: the same-cycle collisions of an edge with an acceptance or a software clear, a disabled re-trigger leaving no missed flag, write-zero clears having no effect, the read-only pending word, and an input held high through reset.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

    localparam int EVT_COUNT  = 20;
    localparam int WORD_W     = 32;
    localparam int SEL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_PEND  = 3'd0,
        SEL_ENA   = 3'd1,
        SEL_PCLR  = 3'd2,
        SEL_MISS  = 3'd3,
        SEL_MCLR  = 3'd4
    } reg_sel_e;

    function automatic int chan_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dma_evt_edge.sv
module dma_evt_edge #(
    parameter int N = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= lvl;
    end

    assign rise = lvl & ~last_q;
endmodule

// File: rtl/dma_evt_arb.sv
module dma_evt_arb #(
    parameter int N = 20,
    parameter int W = 5
) (
    input  logic [N-1:0] req,
    output logic         gnt_valid,
    output logic [W-1:0] gnt_chan
);
    always_comb begin
        gnt_chan = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) gnt_chan = W'(i);
        end
    end

    assign gnt_valid = |req;
endmodule

// File: rtl/dma_evt_regs.sv
module dma_evt_regs #(
    parameter int N = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] serve,
    input  logic [N-1:0] pend_clr,
    input  logic [N-1:0] miss_clr,
    input  logic         ena_we,
    input  logic [N-1:0] ena_wdata,
    output logic [N-1:0] pend,
    output logic [N-1:0] ena,
    output logic [N-1:0] miss
);
    logic [N-1:0] pend_q, ena_q, miss_q;
    logic [N-1:0] miss_set;

    // A re-trigger while pending and enabled is lost, except when the
    // same edge coincides with acceptance (the new edge re-arms the bit).
    assign miss_set = rise & pend_q & ena_q & ~serve;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            ena_q  <= '0;
            miss_q <= '0;
        end else begin
            pend_q <= (pend_q & ~(serve | pend_clr)) | rise;
            miss_q <= (miss_q & ~miss_clr) | miss_set;
            if (ena_we) ena_q <= ena_wdata;
        end
    end

    assign pend = pend_q;
    assign ena  = ena_q;
    assign miss = miss_q;
endmodule

// File: rtl/dma_evt_prio.sv
module dma_evt_prio
    import dma_evt_pkg::*;
#(
    parameter int N_EVT  = EVT_COUNT,
    parameter int DATA_W = WORD_W,
    parameter int ADDR_W = SEL_W,
    parameter int CHAN_W = chan_width(N_EVT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EVT-1:0]  evt_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sub_valid,
    output logic [CHAN_W-1:0] sub_chan,
    input  logic              sub_ready
);
    logic [N_EVT-1:0] rise, serve, pend_clr, miss_clr, req;
    logic [N_EVT-1:0] pend_q, en_q, miss_q;
    logic             ena_we;
    logic             wdata_hi_unused;

    assign wdata_hi_unused = ^reg_wdata[DATA_W-1:N_EVT];

    dma_evt_edge #(.N(N_EVT)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (evt_in),
        .rise (rise)
    );

    assign req = pend_q & en_q;

    dma_evt_arb #(.N(N_EVT), .W(CHAN_W)) u_arb (
        .req       (req),
        .gnt_valid (sub_valid),
        .gnt_chan  (sub_chan)
    );

    assign serve    = (sub_valid && sub_ready) ? (N_EVT'(1) << sub_chan) : '0;
    assign pend_clr = (reg_wr && reg_addr == ADDR_W'(SEL_PCLR)) ? reg_wdata[N_EVT-1:0] : '0;
    assign miss_clr = (reg_wr && reg_addr == ADDR_W'(SEL_MCLR)) ? reg_wdata[N_EVT-1:0] : '0;
    assign ena_we   = reg_wr && reg_addr == ADDR_W'(SEL_ENA);

    dma_evt_regs #(.N(N_EVT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .serve     (serve),
        .pend_clr  (pend_clr),
        .miss_clr  (miss_clr),
        .ena_we    (ena_we),
        .ena_wdata (reg_wdata[N_EVT-1:0]),
        .pend      (pend_q),
        .ena       (en_q),
        .miss      (miss_q)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(SEL_PEND))      reg_rdata[N_EVT-1:0] = pend_q;
        else if (reg_addr == ADDR_W'(SEL_ENA))  reg_rdata[N_EVT-1:0] = en_q;
        else if (reg_addr == ADDR_W'(SEL_MISS)) reg_rdata[N_EVT-1:0] = miss_q;
    end
endmodule

// File: rtl/dma_evt_prio_chk.sv
module dma_evt_prio_chk
    import dma_evt_pkg::*;
#(
    parameter int N_EVT  = EVT_COUNT,
    parameter int DATA_W = WORD_W,
    parameter int ADDR_W = SEL_W,
    parameter int CHAN_W = chan_width(N_EVT)
) (
    input logic              clk,
    input logic              rst,
    input logic [N_EVT-1:0]  evt_in,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              sub_valid,
    input logic [CHAN_W-1:0] sub_chan,
    input logic              sub_ready,
    input logic [N_EVT-1:0]  pend,
    input logic [N_EVT-1:0]  en,
    input logic [N_EVT-1:0]  miss
);
    logic [N_EVT-1:0] seen_q;
    logic [N_EVT-1:0] edge_c;
    logic [N_EVT-1:0] below_c;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else     seen_q <= evt_in;
    end

    assign edge_c  = evt_in & ~seen_q;
    assign below_c = (N_EVT'(1) << sub_chan) - N_EVT'(1);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(SEL_PEND) || reg_addr == ADDR_W'(SEL_ENA))
            |-> reg_rdata[DATA_W-1:N_EVT] == '0); // R1

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        (|edge_c) |=> ((pend & $past(edge_c)) == $past(edge_c))); // R2

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        sub_valid |-> (pend[sub_chan] && en[sub_chan])); // R3

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        sub_valid |-> ((pend & en & below_c) == '0)); // R4

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && sub_ready && !edge_c[sub_chan]) |=> !pend[$past(sub_chan)]); // R5

    AST_MISS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (|edge_c) || !(|edge_c) |=> ((miss & ~$past(miss) & ~$past(pend & en)) == '0)); // R8

    AST_MISS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == ADDR_W'(SEL_MCLR)) |=> (($past(miss) & ~miss) == '0)); // R9
endmodule

bind dma_evt_prio dma_evt_prio_chk #(
    .N_EVT(N_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAN_W(CHAN_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .evt_in    (evt_in),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .sub_valid (sub_valid),
    .sub_chan  (sub_chan),
    .sub_ready (sub_ready),
    .pend      (pend_q),
    .en        (en_q),
    .miss      (miss_q)
);

// File: tb/dma_evt_prio_tb_top.sv
module dma_evt_prio_tb_top;
    localparam int N = 20;
    localparam logic [N-1:0] ALL = '1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] evt_in = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sub_valid;
    logic [4:0]  sub_chan;
    logic        sub_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dma_evt_prio dut_i (
        .clk(clk), .rst(rst), .evt_in(evt_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .sub_valid(sub_valid), .sub_chan(sub_chan), .sub_ready(sub_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [N-1:0] bits);
        @(negedge clk);
        evt_in = evt_in | bits;
        @(negedge clk);
        evt_in = evt_in & ~bits;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [N-1:0] lvl);
        @(negedge clk);
        rst = 1'b1; evt_in = lvl; sub_ready = 1'b0; reg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        do_reset('0);
        @(negedge clk);
        rd(3'd0, d); chk("R11 pending", d, 0);
        rd(3'd1, d); chk("R11 enable", d, 0);
        rd(3'd3, d); chk("R11 missed", d, 0);
        chk("R11 valid", sub_valid, 0);
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        pulse(N'(1) << 5);
        rd(3'd0, d); chk("R2 edge sets while disabled", d, 32'h20);
        chk("R3 disabled not offered", sub_valid, 0);
        pulse(N'(1) << 5);
        rd(3'd3, d); chk("R8 disabled retrigger no miss", d, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); chk("R1 pending word read-only", d, 32'h20);
        wr(3'd2, 32'h0);
        rd(3'd0, d); chk("R6 clear with zero", d, 32'h20);
        rd(3'd2, d); chk("R6 clear reads zero", d, 0);
        wr(3'd2, 32'h20);
        rd(3'd0, d); chk("R6 clear with one", d, 0);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d); chk("R10 enable readback", d, 32'h000F_FFFF);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_prio;
        logic [31:0] d;
        wr(3'd1, 32'(ALL));
        @(negedge clk);
        evt_in = (N'(1) << 3) | (N'(1) << 7) | (N'(1) << 12);
        @(negedge clk);
        evt_in = '0;
        chk("R4 lowest wins valid", sub_valid, 1);
        chk("R4 lowest wins chan", sub_chan, 3);
        @(negedge clk);
        chk("R5 held while not ready", sub_chan, 3);
        sub_ready = 1'b1;
        @(negedge clk);
        sub_ready = 1'b0;
        chk("R5 next after accept", sub_chan, 7);
        rd(3'd0, d); chk("R5 accepted bit cleared", d, 32'h1080);
        wr(3'd1, 32'(ALL & ~(N'(1) << 7)));
        chk("R3 disabled skipped", sub_chan, 12);
        sub_ready = 1'b1;
        @(negedge clk);
        sub_ready = 1'b0;
        chk("R3 only disabled left", sub_valid, 0);
        wr(3'd2, 32'(ALL));
        rd(3'd0, d); chk("R6 clear all", d, 0);
        wr(3'd1, 32'(ALL));
    endtask

    task automatic t_missed;
        logic [31:0] d;
        pulse(N'(1) << 9);
        pulse(N'(1) << 9);
        rd(3'd3, d); chk("R8 enabled retrigger missed", d, 32'h200);
        wr(3'd4, 32'h0);
        @(negedge clk);
        rd(3'd3, d); chk("R9 missed sticky", d, 32'h200);
        wr(3'd4, 32'h200);
        rd(3'd3, d); chk("R9 missed cleared", d, 0);
        chk("R5 offered ch9", sub_chan, 9);
        evt_in[9] = 1'b1; sub_ready = 1'b1;
        @(negedge clk);
        sub_ready = 1'b0;
        rd(3'd0, d); chk("R7 edge with accept keeps bit", d, 32'h200);
        rd(3'd3, d); chk("R8 edge with accept no miss", d, 0);
        evt_in[9] = 1'b0;
        @(negedge clk);
        evt_in[9] = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h200;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; evt_in[9] = 1'b0;
        rd(3'd0, d); chk("R7 edge with sw clear keeps bit", d, 32'h200);
        wr(3'd2, 32'(ALL));
        wr(3'd4, 32'(ALL));
        rd(3'd3, d); chk("R9 clear all missed", d, 0);
    endtask

    task automatic t_high_at_reset;
        logic [31:0] d;
        do_reset(N'(1));
        @(negedge clk);
        rd(3'd0, d); chk("R2 high at reset release", d, 1);
        chk("R11 enable zero after reset", sub_valid, 0);
        evt_in = '0;
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_prio();
        t_missed();
        t_high_at_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule